// File: doc/BRIEF.md
# Opcode-Fetch Triggered Memory Automapper

This block watches the strobes and address of a Z80-style CPU bus and keeps one flag. When the flag is set, an expansion ROM/RAM overlay replaces the host's low 16 kB of memory. Each bus strobe is sampled once per clock. An opcode fetch is a clock in which both `m1_ni` and `mreq_ni` are low. A refresh is a clock in which both `rfsh_ni` and `mreq_ni` are low. The start of a refresh is the first such clock after a clock that was not a refresh.

An opcode fetch from one of the entry addresses arms the mapping. The mapping then takes effect at the start of the refresh that follows. This gives a one-instruction delay, so code can tell a first call from a nested one. An opcode fetch inside the immediate page maps the overlay during the fetch itself. An opcode fetch inside the exit window arms an unmap, and it also takes effect at the refresh. Automatic mapping works only when the ROM-present input or the sticky RAM-as-ROM input is high. A manual-force input from the control logic elsewhere is merged into the overlay-select output.

Top module: `opfetch_automap`

## Requirements
- R1: After reset, `mapped_o` is 0 and `overlay_o` equals `force_i`.
- R2: An opcode fetch from 0x0000, 0x0008, 0x0038, 0x0066, 0x04C6 or 0x0562, while enabled, sets `mapped_o` on the clock edge where the start of the following refresh is sampled.
- R3: During an opcode fetch from an entry address, `mapped_o` keeps the value it had before the fetch.
- R4: An opcode fetch from 0x3D00–0x3DFF, while enabled, sets `mapped_o` on the first clock edge that samples the fetch.
- R5: An opcode fetch from 0x1FF8–0x1FFF clears `mapped_o` on the clock edge where the start of the following refresh is sampled.
- R6: The block is enabled when `rom_present_i` or `mapram_i` is 1. While it is disabled, no fetch sets the flag, and `mapped_o` is 0 from the clock edge after the block is sampled disabled.
- R7: Memory cycles with `m1_ni` high (data reads and writes) never change `mapped_o`, even at entry, exit or immediate-page addresses.
- R8: `overlay_o` is `mapped_o` OR `force_i`, and `force_i` never changes `mapped_o`.
- R9: Once an entry fetch has set the flag, a second fetch of an entry address sees `mapped_o` already 1 throughout that fetch.
- R10: Opcode fetches from any other address leave `mapped_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 16 | CPU address bus |
| m1_ni | input | 1 | Opcode-fetch strobe, active low |
| mreq_ni | input | 1 | Memory-request strobe, active low |
| rfsh_ni | input | 1 | Refresh strobe, active low |
| rom_present_i | input | 1 | ROM-present jumper; enables automapping |
| mapram_i | input | 1 | Sticky RAM-as-ROM flag; enables automapping |
| force_i | input | 1 | Manual overlay force from the control logic |
| mapped_o | output | 1 | Automatic mapping flag |
| overlay_o | output | 1 | Overlay select (automatic or forced) |

## Verification
The case that is hardest to reach is the delayed decision. Here an entry or exit fetch has been latched, but its refresh has not yet come. During that window the flag must still show the old state, and a second fetch must see the state that the first fetch created. The stimulus reaches it with full fetch-then-refresh instruction sequences. Directed pairs of entry fetches are mixed with random streams of fetches and data cycles, in which entry, exit and immediate-page addresses are weighted heavily. The flag is checked in the middle of each fetch and again after each refresh. Enable changes are placed only between instructions.

// File: rtl/oam_pkg.sv
package oam_pkg;
  localparam int ADDR_W  = 16;
  localparam int N_ENTRY = 6;

  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t ENTRY_ADDR [N_ENTRY] = '{
    16'h0000, 16'h0008, 16'h0038, 16'h0066, 16'h04C6, 16'h0562
  };

  // exit window: 1FF8..1FFF, immediate page: 3D00..3DFF
  localparam addr_t EXIT_BASE = 16'h1FF8;
  localparam int    EXIT_LSB  = 3;
  localparam addr_t IMM_BASE  = 16'h3D00;
  localparam int    IMM_LSB   = 8;

  typedef struct packed {
    logic entry;
    logic exit_w;
    logic imm;
  } hit_t;
endpackage

// File: rtl/oam_addr_match.sv
module oam_addr_match
  import oam_pkg::*;
#(
  parameter int    AW       = ADDR_W,
  parameter int    NE       = N_ENTRY,
  parameter int    X_LSB    = EXIT_LSB,
  parameter int    I_LSB    = IMM_LSB
) (
  input  logic [AW-1:0] addr_i,
  output hit_t          hit_o
);
  localparam int XH = AW - X_LSB;
  localparam int IH = AW - I_LSB;

  logic [NE-1:0] ent_vec;

  for (genvar g = 0; g < NE; g++) begin : g_ent
    assign ent_vec[g] = (addr_i == ENTRY_ADDR[g][AW-1:0]);
  end

  logic [XH-1:0] exit_tag;
  logic [IH-1:0] imm_tag;
  assign exit_tag = EXIT_BASE[AW-1:X_LSB];
  assign imm_tag  = IMM_BASE[AW-1:I_LSB];

  always_comb begin
    hit_o        = '0;
    hit_o.entry  = |ent_vec;
    hit_o.exit_w = (addr_i[AW-1:X_LSB] == exit_tag);
    hit_o.imm    = (addr_i[AW-1:I_LSB] == imm_tag);
  end
endmodule

// File: rtl/oam_bus_phase.sv
module oam_bus_phase (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic m1_ni,
  input  logic mreq_ni,
  input  logic rfsh_ni,
  output logic fetch_o,
  output logic rfsh_start_o
);
  logic rfsh_act, rfsh_q;

  assign fetch_o  = ~m1_ni & ~mreq_ni;
  assign rfsh_act = ~rfsh_ni & ~mreq_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rfsh_q <= 1'b0;
    else         rfsh_q <= rfsh_act;
  end

  assign rfsh_start_o = rfsh_act & ~rfsh_q;
endmodule

// File: rtl/oam_map_state.sv
module oam_map_state
  import oam_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic fetch_i,
  input  logic rfsh_start_i,
  input  hit_t hit_i,
  output logic mapped_o
);
  logic mapped_q, pend_on_q, pend_off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mapped_q   <= 1'b0;
      pend_on_q  <= 1'b0;
      pend_off_q <= 1'b0;
    end else if (!en_i) begin
      mapped_q   <= 1'b0;
      pend_on_q  <= 1'b0;
      pend_off_q <= 1'b0;
    end else begin
      if (fetch_i) begin
        if (hit_i.entry)  pend_on_q  <= 1'b1;
        if (hit_i.exit_w) pend_off_q <= 1'b1;
        if (hit_i.imm)    mapped_q   <= 1'b1;
      end
      // deferred decision lands at refresh start
      if (rfsh_start_i) begin
        pend_on_q  <= 1'b0;
        pend_off_q <= 1'b0;
        if (pend_on_q)       mapped_q <= 1'b1;
        else if (pend_off_q) mapped_q <= 1'b0;
      end
    end
  end

  assign mapped_o = mapped_q;
endmodule

// File: rtl/opfetch_automap.sv
module opfetch_automap
  import oam_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              m1_ni,
  input  logic              mreq_ni,
  input  logic              rfsh_ni,
  input  logic              rom_present_i,
  input  logic              mapram_i,
  input  logic              force_i,
  output logic              mapped_o,
  output logic              overlay_o
);
  hit_t hit;
  logic fetch, rfsh_start, en;

  assign en = rom_present_i | mapram_i;

  oam_addr_match i_match (
    .addr_i (addr_i),
    .hit_o  (hit)
  );

  oam_bus_phase i_phase (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .m1_ni        (m1_ni),
    .mreq_ni      (mreq_ni),
    .rfsh_ni      (rfsh_ni),
    .fetch_o      (fetch),
    .rfsh_start_o (rfsh_start)
  );

  oam_map_state i_state (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en),
    .fetch_i      (fetch),
    .rfsh_start_i (rfsh_start),
    .hit_i        (hit),
    .mapped_o     (mapped_o)
  );

  assign overlay_o = mapped_o | force_i;
endmodule

// File: rtl/oam_chk.sv
module oam_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] addr_i,
  input logic        m1_ni,
  input logic        mreq_ni,
  input logic        rfsh_ni,
  input logic        rom_present_i,
  input logic        mapram_i,
  input logic        force_i,
  input logic        mapped_o,
  input logic        overlay_o
);
  logic en;
  assign en = rom_present_i | mapram_i;

  // R2 R4
  rise_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mapped_o) |-> ($past(!rfsh_ni && !mreq_ni) ||
                         $past(!m1_ni && !mreq_ni && addr_i[15:8] == 8'h3D)));

  // R5
  fall_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mapped_o) |-> ($past(!rfsh_ni && !mreq_ni) || $past(!en)));

  // R6
  disable_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> !mapped_o);

  // R7
  data_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m1_ni && rfsh_ni && en) |=> $stable(mapped_o));

  // R8
  force_ovl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_i |-> overlay_o);
endmodule

bind opfetch_automap oam_chk i_oam_chk (.*);

// File: tb/test_opfetch_automap.sv
module test_opfetch_automap;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        m1_n = 1'b1, mreq_n = 1'b1, rfsh_n = 1'b1;
  logic        rom_p = 1'b1, mapram = 1'b0, frc = 1'b0;
  logic        mapped, overlay;
  int          n_chk = 0, n_err = 0;
  logic        exp_m = 1'b0;

  always #2.5 clk = ~clk;

  opfetch_automap i_opfetch_automap (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .m1_ni(m1_n), .mreq_ni(mreq_n),
    .rfsh_ni(rfsh_n), .rom_present_i(rom_p), .mapram_i(mapram), .force_i(frc),
    .mapped_o(mapped), .overlay_o(overlay)
  );

  function automatic logic is_entry(input logic [15:0] a);
    return a == 16'h0000 || a == 16'h0008 || a == 16'h0038 ||
           a == 16'h0066 || a == 16'h04C6 || a == 16'h0562;
  endfunction
  function automatic logic is_exit(input logic [15:0] a);
    return a >= 16'h1FF8 && a <= 16'h1FFF;
  endfunction
  function automatic logic is_imm(input logic [15:0] a);
    return a[15:8] == 8'h3D;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      m1_n = 1'b1; mreq_n = 1'b1; rfsh_n = 1'b1;
    end
  endtask

  // full M1 cycle: 2 clocks fetch, 2 clocks refresh
  task automatic opfetch(input logic [15:0] a, input string req);
    logic en, mid, fin;
    en  = rom_p | mapram;
    mid = (en && is_imm(a)) ? 1'b1 : exp_m;
    fin = !en ? 1'b0 : is_entry(a) ? 1'b1 : is_exit(a) ? 1'b0 : mid;
    @(negedge clk);
    addr = a; m1_n = 1'b0; mreq_n = 1'b0; rfsh_n = 1'b1;
    @(negedge clk);
    check(req, mapped, mid);
    check({req, " ovl R8"}, overlay, mid | frc);
    @(negedge clk);
    addr = $urandom; m1_n = 1'b1; mreq_n = 1'b0; rfsh_n = 1'b0;
    @(negedge clk);
    check(req, mapped, fin);
    @(negedge clk);
    mreq_n = 1'b1; rfsh_n = 1'b1;
    exp_m = fin;
  endtask

  task automatic datacyc(input logic [15:0] a);
    @(negedge clk);
    addr = a; m1_n = 1'b1; mreq_n = 1'b0; rfsh_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    mreq_n = 1'b1;
    check("R7 data cycle", mapped, exp_m);
  endtask

  task automatic set_en(input logic r, input logic m);
    @(negedge clk);
    rom_p = r; mapram = m;
    idle(1);
    if (!(r | m)) exp_m = 1'b0;
    check("R6 enable change", mapped, exp_m);
  endtask

  function automatic logic [15:0] pick_addr();
    case ($urandom_range(0, 4))
      0: case ($urandom_range(0, 5))
           0: return 16'h0000; 1: return 16'h0008; 2: return 16'h0038;
           3: return 16'h0066; 4: return 16'h04C6; default: return 16'h0562;
         endcase
      1: return 16'h1FF8 + 16'($urandom_range(0, 7));
      2: return 16'h3D00 + 16'($urandom_range(0, 255));
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    #400000;
    n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    idle(3);
    check("R1 reset mapped", mapped, 1'b0);
    check("R1 reset overlay", overlay, 1'b0);
    rst_n = 1'b1;
    idle(2);
    check("R1 after release", mapped, 1'b0);

    opfetch(16'h1234, "R10 other fetch");
    opfetch(16'h0038, "R2 R3 entry 0038");
    opfetch(16'h0038, "R9 second entry fetch");
    opfetch(16'h1FFB, "R5 exit");
    opfetch(16'h0066, "R2 entry 0066");
    opfetch(16'h4000, "R10 other while mapped");
    opfetch(16'h1FFF, "R5 exit top");
    opfetch(16'h1FF7, "R10 below exit");
    opfetch(16'h3D42, "R4 immediate page");
    opfetch(16'h1FF8, "R5 exit base");
    opfetch(16'h3E00, "R10 above imm page");
    datacyc(16'h0000);
    datacyc(16'h3D10);
    opfetch(16'h04C6, "R2 entry 04C6");
    datacyc(16'h1FFC);
    frc = 1'b1;
    idle(1);
    check("R8 force overlay", overlay, 1'b1);
    opfetch(16'h1FF9, "R8 R5 exit under force");
    frc = 1'b0;
    set_en(1'b0, 1'b1);
    opfetch(16'h0562, "R6 mapram enables");
    set_en(1'b0, 1'b0);
    check("R6 disabled clears", mapped, 1'b0);
    opfetch(16'h0000, "R6 disabled entry");
    opfetch(16'h3D00, "R6 disabled imm");
    set_en(1'b1, 1'b0);
    opfetch(16'h0008, "R2 entry 0008");

    for (int i = 0; i < 600; i++) begin
      case ($urandom_range(0, 9))
        0: set_en(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)));
        1, 2: datacyc(pick_addr());
        3: begin frc = 1'($urandom); idle(1); end
        default: opfetch(pick_addr(), "R2 R4 R5 R10 random");
      endcase
    end

    idle(2);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule